// File: doc/BRIEF.md
# Shared-Cache Word Registry Bank Controller

This block controls one bank of a shared cache used under a data-race-free coherence scheme. There is no sharer directory. When a private L1 takes write ownership of a word, the bank overwrites that word's data field with the owner's core number and sets a per-word "registered" flag. Each line also carries a valid flag and a dirty flag. Readers are never recorded.

L1 requests arrive one at a time on a request port. Each request carries an opcode, the source core, a predicted owner, a line, a word and data. Each accepted request produces at most one response on a registered response port, with one exception: a registration that takes a word from another core produces two responses on consecutive cycles. The first is a revoke to the old owner and the second is an acknowledge to the new owner. During the cycle between them the request port is not ready.

The bank also arbitrates direct reads. A core may have sent a read straight to the L1 it predicted as owner, and the bank reports that request with the predicted core. If the prediction is correct, the read is forwarded to that owner. If it is wrong, the requester is refused and retries through the bank. Line refill from memory is outside this block; a fill opcode simply deposits one word.

Top module: `regbank_ctrl`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and every line is invalid.
- R2: A fill (op 3) writes req_data into an unregistered word and sets its line valid, and produces no response. A fill aimed at a registered word changes nothing.
- R3: A read (op 0) of an unregistered word in a valid line returns kind 0 (data) on the next cycle, with the word value and the line's dirty flag in rsp_dirty. rsp_dirty is 0 for every other kind.
- R4: A read of an unregistered word in an invalid line returns kind 6 (miss).
- R5: A read of a registered word returns kind 1 (forward), with rsp_dst set to the owner held in the word's low bits, rsp_req set to the requester and rsp_data 0.
- R6: A registration (op 1) of an unregistered word returns kind 2 (register acknowledge) to the requester, carrying the word's prior data. The word then holds the requester's number and is marked registered.
- R7: A registration of a word owned by a different core first returns kind 3 (revoke), with rsp_dst set to the old owner and rsp_req set to the new one. On the following cycle it returns kind 2 to the new owner with data 0. req_ready is 0 in the cycle between the two responses.
- R8: A registration by the core that already owns the word returns a single kind 2 with data 0.
- R9: A writeback (op 2) from the owner stores req_data in the word, clears the registered flag, sets the line dirty and valid, and returns kind 4 (writeback acknowledge).
- R10: A writeback from any core that is not the owner returns kind 4 and changes no state.
- R11: A predicted read (op 4) returns kind 1 to the owner when the word is registered to the core named in req_pred. In every other case it returns kind 5 (refusal) to the requester.
- R12: Opcodes 5 to 7 produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request this cycle |
| req_op | input | 3 | Opcode: 0 read, 1 register, 2 writeback, 3 fill, 4 predicted read |
| req_src | input | ID_W | Requesting core |
| req_pred | input | ID_W | Core predicted as owner (op 4) |
| req_line | input | LINE_W | Line index |
| req_word | input | WORD_W | Word index in line |
| req_data | input | DATA_W | Writeback or fill data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_kind | output | 3 | 0 data, 1 forward, 2 reg ack, 3 revoke, 4 wb ack, 5 refusal, 6 miss |
| rsp_dst | output | ID_W | Core that receives the response |
| rsp_req | output | ID_W | Core that originated the request |
| rsp_line | output | LINE_W | Line index of the request |
| rsp_word | output | WORD_W | Word index of the request |
| rsp_data | output | DATA_W | Word data where defined, else 0 |
| rsp_dirty | output | 1 | Line dirty flag on data responses |

## Verification
Reads are issued against words in four different states: in an invalid line, filled, registered, and restored by writeback. This separates the miss, data and forward paths, and shows that a forward names the owner written into the data field rather than stale data. Registrations are made by a fresh core, by the current owner and by a rival core, to separate the single acknowledge from the revoke-then-acknowledge pair and its stall. Writebacks, fills and undefined opcodes are sent both from the owner and from non-owners, each followed by a read, so that a dropped request can be seen at the ports. Predicted reads are sent with a correct guess, a wrong guess and an unregistered word.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam logic [2:0] OP_READ = 3'd0;
  localparam logic [2:0] OP_REG  = 3'd1;
  localparam logic [2:0] OP_WB   = 3'd2;
  localparam logic [2:0] OP_FILL = 3'd3;
  localparam logic [2:0] OP_PRED = 3'd4;

  typedef enum logic [2:0] {
    K_DATA    = 3'd0,
    K_FWD     = 3'd1,
    K_REG_ACK = 3'd2,
    K_REVOKE  = 3'd3,
    K_WB_ACK  = 3'd4,
    K_NACK    = 3'd5,
    K_MISS    = 3'd6
  } rsp_kind_e;
endpackage

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int N_LINES = 8,
  parameter int N_WORDS = 4,
  parameter int DATA_W  = 32,
  localparam int LINE_W = $clog2(N_LINES),
  localparam int WORD_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_reg,
  output logic              rd_valid,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_reg,
  input  logic              set_valid,
  input  logic              set_dirty
);
  logic [N_WORDS-1:0][DATA_W-1:0] line_words [N_LINES];
  logic [N_WORDS-1:0]             line_regs  [N_LINES];
  logic [N_LINES-1:0]             line_valid;
  logic [N_LINES-1:0]             line_dirty;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [N_WORDS-1:0][DATA_W-1:0] words_q;
    logic [N_WORDS-1:0]             regs_q;
    logic                           valid_q;
    logic                           dirty_q;
    logic                           hit;

    assign hit = wr_en && (wr_line == LINE_W'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words_q <= '0;
        regs_q  <= '0;
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end else begin
        if (hit) begin
          words_q[wr_word] <= wr_data;
          regs_q[wr_word]  <= wr_reg;
        end
        if (hit && set_valid) valid_q <= 1'b1;
        if (hit && set_dirty) dirty_q <= 1'b1;
      end
    end

    assign line_words[l] = words_q;
    assign line_regs[l]  = regs_q;
    assign line_valid[l] = valid_q;
    assign line_dirty[l] = dirty_q;
  end

  always_comb begin
    rd_data  = line_words[rd_line][rd_word];
    rd_reg   = line_regs[rd_line][rd_word];
    rd_valid = line_valid[rd_line];
    rd_dirty = line_dirty[rd_line];
  end
endmodule

// File: rtl/regbank_decide.sv
module regbank_decide
  import regbank_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int DATA_W = 32
) (
  input  logic              accept,
  input  logic [2:0]        op,
  input  logic [ID_W-1:0]   src,
  input  logic [ID_W-1:0]   pred,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_reg,
  input  logic              st_valid,
  input  logic              st_dirty,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_reg,
  output logic              set_valid,
  output logic              set_dirty,
  output logic              d_vld,
  output logic [2:0]        d_kind,
  output logic [ID_W-1:0]   d_dst,
  output logic [DATA_W-1:0] d_data,
  output logic              d_dirty,
  output logic              d_follow
);
  logic [ID_W-1:0] owner;
  assign owner = st_data[ID_W-1:0];

  always_comb begin
    wr_en     = 1'b0;
    wr_data   = in_data;
    wr_reg    = 1'b0;
    set_valid = 1'b0;
    set_dirty = 1'b0;
    d_vld     = 1'b0;
    d_kind    = K_DATA;
    d_dst     = src;
    d_data    = '0;
    d_dirty   = 1'b0;
    d_follow  = 1'b0;
    if (accept) begin
      case (op)
        OP_READ: begin
          d_vld = 1'b1;
          if (st_reg) begin
            d_kind = K_FWD;
            d_dst  = owner;
          end else if (!st_valid) begin
            d_kind = K_MISS;
          end else begin
            d_kind  = K_DATA;
            d_data  = st_data;
            d_dirty = st_dirty;
          end
        end
        OP_PRED: begin
          d_vld = 1'b1;
          if (st_reg && (owner == pred)) begin
            d_kind = K_FWD;
            d_dst  = owner;
          end else begin
            d_kind = K_NACK;
          end
        end
        OP_REG: begin
          d_vld   = 1'b1;
          wr_en   = 1'b1;
          wr_data = DATA_W'(src);
          wr_reg  = 1'b1;
          if (st_reg && (owner != src)) begin
            d_kind   = K_REVOKE;
            d_dst    = owner;
            d_follow = 1'b1;
          end else begin
            d_kind = K_REG_ACK;
            d_data = st_reg ? '0 : st_data;
          end
        end
        OP_WB: begin
          d_vld  = 1'b1;
          d_kind = K_WB_ACK;
          if (st_reg && (owner == src)) begin
            wr_en     = 1'b1;
            set_valid = 1'b1;
            set_dirty = 1'b1;
          end
        end
        OP_FILL: begin
          if (!st_reg) begin
            wr_en     = 1'b1;
            set_valid = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regbank_out.sv
module regbank_out
  import regbank_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int LINE_W = 3,
  parameter int WORD_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_vld,
  input  logic [2:0]        d_kind,
  input  logic [ID_W-1:0]   d_dst,
  input  logic [ID_W-1:0]   d_req,
  input  logic [LINE_W-1:0] d_line,
  input  logic [WORD_W-1:0] d_word,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_dirty,
  input  logic              d_follow,
  output logic              ready,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [ID_W-1:0]   rsp_dst,
  output logic [ID_W-1:0]   rsp_req,
  output logic [LINE_W-1:0] rsp_line,
  output logic [WORD_W-1:0] rsp_word,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty
);
  logic              pend_q, pend_n;
  logic [ID_W-1:0]   pid_q, pid_n;
  logic [LINE_W-1:0] pline_q, pline_n;
  logic [WORD_W-1:0] pword_q, pword_n;

  logic              n_vld;
  logic [2:0]        n_kind;
  logic [ID_W-1:0]   n_dst, n_req;
  logic [LINE_W-1:0] n_line;
  logic [WORD_W-1:0] n_word;
  logic [DATA_W-1:0] n_data;
  logic              n_dirty;

  assign ready = !pend_q;

  always_comb begin
    pend_n  = 1'b0;
    pid_n   = pid_q;
    pline_n = pline_q;
    pword_n = pword_q;
    if (pend_q) begin
      n_vld   = 1'b1;
      n_kind  = K_REG_ACK;
      n_dst   = pid_q;
      n_req   = pid_q;
      n_line  = pline_q;
      n_word  = pword_q;
      n_data  = '0;
      n_dirty = 1'b0;
    end else begin
      n_vld   = d_vld;
      n_kind  = d_kind;
      n_dst   = d_dst;
      n_req   = d_req;
      n_line  = d_line;
      n_word  = d_word;
      n_data  = d_data;
      n_dirty = d_dirty;
      if (d_follow) begin
        pend_n  = 1'b1;
        pid_n   = d_req;
        pline_n = d_line;
        pword_n = d_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pid_q   <= '0;
      pline_q <= '0;
      pword_q <= '0;
    end else begin
      pend_q <= pend_n;
      if (pend_n) begin
        pid_q   <= pid_n;
        pline_q <= pline_n;
        pword_q <= pword_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= '0;
      rsp_dst   <= '0;
      rsp_req   <= '0;
      rsp_line  <= '0;
      rsp_word  <= '0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= n_vld;
      if (n_vld) begin
        rsp_kind  <= n_kind;
        rsp_dst   <= n_dst;
        rsp_req   <= n_req;
        rsp_line  <= n_line;
        rsp_word  <= n_word;
        rsp_data  <= n_data;
        rsp_dirty <= n_dirty;
      end
    end
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_LINES = 8,
  parameter int N_WORDS = 4,
  parameter int DATA_W  = 32,
  localparam int ID_W   = $clog2(N_CORES),
  localparam int LINE_W = $clog2(N_LINES),
  localparam int WORD_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ID_W-1:0]   req_src,
  input  logic [ID_W-1:0]   req_pred,
  input  logic [LINE_W-1:0] req_line,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_kind,
  output logic [ID_W-1:0]   rsp_dst,
  output logic [ID_W-1:0]   rsp_req,
  output logic [LINE_W-1:0] rsp_line,
  output logic [WORD_W-1:0] rsp_word,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              accept;
  logic [DATA_W-1:0] st_data;
  logic              st_reg, st_valid, st_dirty;
  logic              wr_en, wr_reg, set_valid, set_dirty;
  logic [DATA_W-1:0] wr_data;
  logic              d_vld, d_dirty, d_follow;
  logic [2:0]        d_kind;
  logic [ID_W-1:0]   d_dst;
  logic [DATA_W-1:0] d_data;

  assign accept = req_valid && req_ready && rst_n_int;

  regbank_store #(
    .N_LINES(N_LINES), .N_WORDS(N_WORDS), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n_int),
    .rd_line(req_line), .rd_word(req_word),
    .rd_data(st_data), .rd_reg(st_reg), .rd_valid(st_valid), .rd_dirty(st_dirty),
    .wr_en(wr_en), .wr_line(req_line), .wr_word(req_word), .wr_data(wr_data),
    .wr_reg(wr_reg), .set_valid(set_valid), .set_dirty(set_dirty)
  );

  regbank_decide #(.ID_W(ID_W), .DATA_W(DATA_W)) u_decide (
    .accept(accept), .op(req_op), .src(req_src), .pred(req_pred),
    .in_data(req_data), .st_data(st_data), .st_reg(st_reg),
    .st_valid(st_valid), .st_dirty(st_dirty),
    .wr_en(wr_en), .wr_data(wr_data), .wr_reg(wr_reg),
    .set_valid(set_valid), .set_dirty(set_dirty),
    .d_vld(d_vld), .d_kind(d_kind), .d_dst(d_dst), .d_data(d_data),
    .d_dirty(d_dirty), .d_follow(d_follow)
  );

  regbank_out #(
    .ID_W(ID_W), .LINE_W(LINE_W), .WORD_W(WORD_W), .DATA_W(DATA_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n_int),
    .d_vld(d_vld), .d_kind(d_kind), .d_dst(d_dst), .d_req(req_src),
    .d_line(req_line), .d_word(req_word), .d_data(d_data),
    .d_dirty(d_dirty), .d_follow(d_follow),
    .ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
    .rsp_req(rsp_req), .rsp_line(rsp_line), .rsp_word(rsp_word),
    .rsp_data(rsp_data), .rsp_dirty(rsp_dirty)
  );
endmodule

// File: rtl/regbank_ctrl_chk.sv
module regbank_ctrl_chk
  import regbank_pkg::*;
#(
  parameter int ID_W = 2
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic [ID_W-1:0] req_src,
  input logic            rsp_valid,
  input logic [2:0]      rsp_kind,
  input logic [ID_W-1:0] rsp_dst,
  input logic [ID_W-1:0] rsp_req,
  input logic            rsp_dirty
);
  logic acc;
  assign acc = req_valid && req_ready;

  always @(posedge clk) begin
    if (rst_ni === 1'b0) begin
      p_reset_idle_r1: assert (!rsp_valid && req_ready)
        else $error("reset state wrong");
    end
  end

  p_fill_silent_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && req_op == OP_FILL) |=> !rsp_valid);

  p_dirty_only_data_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_kind != K_DATA) |-> !rsp_dirty);

  p_read_kinds_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && req_op == OP_READ) |=>
      (rsp_valid && (rsp_kind == K_DATA || rsp_kind == K_FWD || rsp_kind == K_MISS)));

  p_revoke_then_ack_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_kind == K_REVOKE) |=>
      (rsp_valid && rsp_kind == K_REG_ACK && rsp_dst == $past(rsp_req)));

  p_stall_only_after_revoke_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_ready |-> (rsp_valid && rsp_kind == K_REVOKE));

  p_wb_ack_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && req_op == OP_WB) |=>
      (rsp_valid && rsp_kind == K_WB_ACK && rsp_dst == $past(req_src)));

  p_pred_kinds_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && req_op == OP_PRED) |=>
      (rsp_valid && (rsp_kind == K_FWD || rsp_kind == K_NACK)));

  p_undef_silent_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc && req_op > OP_PRED) |=> !rsp_valid);
endmodule

bind regbank_ctrl regbank_ctrl_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_ni(rst_n_int),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_src(req_src),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
  .rsp_req(rsp_req), .rsp_dirty(rsp_dirty)
);

// File: tb/regbank_ctrl_bench.sv
module regbank_ctrl_bench;
  localparam int ID_W   = 2;
  localparam int LINE_W = 3;
  localparam int WORD_W = 2;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_op = '0;
  logic [ID_W-1:0]   req_src = '0;
  logic [ID_W-1:0]   req_pred = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic [WORD_W-1:0] req_word = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic              rsp_valid;
  logic [2:0]        rsp_kind;
  logic [ID_W-1:0]   rsp_dst, rsp_req;
  logic [LINE_W-1:0] rsp_line;
  logic [WORD_W-1:0] rsp_word;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_dirty;

  always #2.5 clk = ~clk;

  regbank_ctrl u_regbank_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_src(req_src), .req_pred(req_pred), .req_line(req_line),
    .req_word(req_word), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
    .rsp_req(rsp_req), .rsp_line(rsp_line), .rsp_word(rsp_word),
    .rsp_data(rsp_data), .rsp_dirty(rsp_dirty)
  );

  typedef struct {
    logic [2:0]        kind;
    logic [ID_W-1:0]   dst;
    logic [ID_W-1:0]   rq;
    logic [LINE_W-1:0] line;
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] data;
    logic              dirty;
    string             tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   monitor_on = 1'b0;
  bit   finished = 1'b0;

  logic [DATA_W-1:0] m_word  [8][4];
  logic              m_reg   [8][4];
  logic              m_valid [8];
  logic              m_dirty [8];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [ID_W-1:0] d,
                      input logic [ID_W-1:0] r, input int l, input int w,
                      input logic [DATA_W-1:0] dat, input logic dty, input string tag);
    exp_t e;
    e.kind = k; e.dst = d; e.rq = r; e.line = LINE_W'(l); e.word = WORD_W'(w);
    e.data = dat; e.dirty = dty; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: predicts the responses from the requirements, updates the model, drives.
  task automatic do_req(input int op, input int src, input int pred, input int l,
                        input int w, input logic [DATA_W-1:0] dat);
    logic [ID_W-1:0] own;
    logic [ID_W-1:0] s;
    s   = ID_W'(src);
    own = m_word[l][w][ID_W-1:0];
    case (op)
      0: begin
        if (m_reg[l][w])      push(3'd1, own, s, l, w, '0, 1'b0, "R5");
        else if (!m_valid[l]) push(3'd6, s, s, l, w, '0, 1'b0, "R4");
        else                  push(3'd0, s, s, l, w, m_word[l][w], m_dirty[l], "R3");
      end
      4: begin
        if (m_reg[l][w] && own == ID_W'(pred)) push(3'd1, own, s, l, w, '0, 1'b0, "R11");
        else                                   push(3'd5, s, s, l, w, '0, 1'b0, "R11");
      end
      1: begin
        if (m_reg[l][w] && own != s) begin
          push(3'd3, own, s, l, w, '0, 1'b0, "R7");
          push(3'd2, s, s, l, w, '0, 1'b0, "R7");
        end else if (m_reg[l][w]) begin
          push(3'd2, s, s, l, w, '0, 1'b0, "R8");
        end else begin
          push(3'd2, s, s, l, w, m_word[l][w], 1'b0, "R6");
        end
        m_word[l][w] = DATA_W'(s);
        m_reg[l][w]  = 1'b1;
      end
      2: begin
        if (m_reg[l][w] && own == s) begin
          push(3'd4, s, s, l, w, '0, 1'b0, "R9");
          m_word[l][w] = dat;
          m_reg[l][w]  = 1'b0;
          m_dirty[l]   = 1'b1;
          m_valid[l]   = 1'b1;
        end else begin
          push(3'd4, s, s, l, w, '0, 1'b0, "R10");
        end
      end
      3: begin
        if (!m_reg[l][w]) begin
          m_word[l][w] = dat;
          m_valid[l]   = 1'b1;
        end
      end
      default: ;
    endcase
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_op    = 3'(op);
    req_src   = s;
    req_pred  = ID_W'(pred);
    req_line  = LINE_W'(l);
    req_word  = WORD_W'(w);
    req_data  = dat;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Monitor: pops expected items as responses appear.
  always @(negedge clk) begin
    if (monitor_on && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12", "unexpected response kind", rsp_kind, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_kind == e.kind, e.tag, "kind", rsp_kind, e.kind);
        check(rsp_dst == e.dst && rsp_req == e.rq, e.tag, "dst/req",
              {rsp_dst, rsp_req}, {e.dst, e.rq});
        check(rsp_line == e.line && rsp_word == e.word, e.tag, "line/word",
              {rsp_line, rsp_word}, {e.line, e.word});
        check(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
        check(rsp_dirty == e.dirty, e.tag, "dirty", rsp_dirty, e.dirty);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int l = 0; l < 8; l++) begin
      m_valid[l] = 1'b0;
      m_dirty[l] = 1'b0;
      for (int w = 0; w < 4; w++) begin
        m_word[l][w] = '0;
        m_reg[l][w]  = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    monitor_on = 1'b1;

    do_req(0, 0, 0, 0, 0, '0);                 // R4/R1 invalid line miss
    for (int w = 0; w < 4; w++) do_req(3, 0, 0, 0, w, 32'hA000_0010 + 32'(w)); // R2
    do_req(0, 3, 0, 0, 1, '0);                 // R3 data, clean
    do_req(0, 2, 0, 0, 3, '0);                 // R3
    do_req(1, 1, 0, 0, 1, '0);                 // R6 register fresh
    do_req(0, 2, 0, 0, 1, '0);                 // R5 forward to core 1
    do_req(4, 3, 1, 0, 1, '0);                 // R11 right guess
    do_req(4, 3, 2, 0, 1, '0);                 // R11 wrong guess
    do_req(4, 3, 0, 0, 2, '0);                 // R11 unregistered word
    do_req(1, 2, 0, 0, 1, '0);                 // R7 revoke then ack
    @(negedge clk);
    check(req_ready == 1'b0, "R7", "req_ready between revoke and ack", req_ready, 0);
    do_req(1, 2, 0, 0, 1, '0);                 // R8 same owner
    do_req(2, 1, 0, 0, 1, 32'hDEAD_BEEF);      // R10 non-owner writeback
    do_req(0, 0, 0, 0, 1, '0);                 // R10 still forwarded to core 2
    do_req(3, 0, 0, 0, 1, 32'h1111_2222);      // R2 fill on registered word ignored
    do_req(0, 3, 0, 0, 1, '0);                 // R2 still forwarded
    do_req(6, 1, 0, 0, 0, 32'h5555_5555);      // R12 undefined op
    do_req(5, 1, 0, 0, 0, 32'h6666_6666);      // R12
    do_req(7, 2, 0, 0, 0, 32'h7777_7777);      // R12
    do_req(0, 1, 0, 0, 0, '0);                 // R12 word unchanged
    do_req(2, 2, 0, 0, 1, 32'hCAFE_F00D);      // R9 owner writeback
    do_req(0, 0, 0, 0, 1, '0);                 // R9 restored, dirty
    do_req(0, 0, 0, 0, 2, '0);                 // R3 dirty on neighbour word
    do_req(2, 0, 0, 3, 0, 32'h1234_5678);      // R10 writeback on unregistered, invalid line
    do_req(0, 0, 0, 3, 0, '0);                 // R4 still miss

    for (int l = 4; l < 8; l++) begin
      for (int w = 0; w < 4; w++) begin
        do_req(3, 0, 0, l, w, {8'(l), 8'(w), 16'h5A00 + 16'(l * 4 + w)});
        do_req(0, (l + w) % 4, 0, l, w, '0);
        do_req(1, (l + w) % 4, 0, l, w, '0);
        do_req(0, (l + w + 1) % 4, 0, l, w, '0);
        do_req(4, (l + w + 2) % 4, (l + w) % 4, l, w, '0);
        do_req(4, (l + w + 2) % 4, (l + w + 3) % 4, l, w, '0);
        if (w[0]) do_req(1, (l + w + 1) % 4, 0, l, w, '0);
        do_req(2, w[0] ? (l + w + 1) % 4 : (l + w) % 4, 0, l, w, ~32'(l * 7 + w));
        do_req(0, 0, 0, l, w, '0);
      end
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "responses outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule